// File: doc/BRIEF.md
# Register Transfer Unit with Post-Move Step

This block carries out the register-to-register transfer group of a small microsequencer. It holds its own file of 16-bit registers. A request names a source register (Ry), a destination register (Rx) and a 3-bit sub-function. The unit can copy a whole halfword, move one byte into the other byte lane, or copy and then add or subtract 1 or 2 from the value written. The result goes back into Rx. The write-back data, the write enable and the destination index are registered and appear on the outputs one cycle after the request.

The register file has two combinational read ports, one for the destination and one for the source, and one write port. A request reads the file as it stands after the write from the request before it. Requests can therefore be issued back to back with no forwarding path. Only Rx is ever written, so Ry changes only when it names the same register as Rx.

Top module: `rtu_xfer_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `wb_en_o` is 0 and `wb_data_o` is 0. Register i of the file holds the low 16 bits of `(i * 0x1357) XOR 0xA5C3`.
- R2: Sub-function 0 (full copy) writes the whole value of Ry into Rx.
- R3: Sub-function 1 writes the upper byte of Ry into the lower byte of Rx. The upper byte of Rx keeps its previous value.
- R4: Sub-function 2 writes the lower byte of Ry into the upper byte of Rx. The lower byte of Rx keeps its previous value.
- R5: Sub-functions 3 and 4 write Ry minus 1 and Ry minus 2 into Rx, with wrap-around modulo 2^16.
- R6: Sub-functions 5 and 6 write Ry plus 1 and Ry plus 2 into Rx, with wrap-around modulo 2^16.
- R7: No register other than Rx changes. When Ry and Rx are the same index, that register takes the result.
- R8: When `valid_i` is low, or when the sub-function code is 7, nothing is written, `wb_en_o` is 0 and `wb_data_o` is 0.
- R9: `wb_en_o`, `wb_idx_o` (equal to Rx) and `wb_data_o` appear on the clock edge that accepts the request. A request in the very next cycle reads the updated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| func_i | input | 3 | Sub-function code |
| rx_i | input | 4 | Destination register index |
| ry_i | input | 4 | Source register index |
| wb_en_o | output | 1 | Register write performed this cycle |
| wb_idx_o | output | 4 | Index of the register written |
| wb_data_o | output | 16 | Value written |

## Verification
Every sub-function is applied to registers that start from distinct reset values. A swapped byte lane or a kept byte taken from the wrong register therefore shows up as a wrong value. Requests that use the same index for Rx and Ry are mixed with requests that use different indices. A later full copy out of the old source then shows whether Ry was disturbed. A long chain of self-increments pushes one register up to 0xFFFF, so that the +2 and -2 steps cross the wrap boundary in both directions. Idle cycles and code 7 requests sit between back-to-back requests to confirm that nothing is written on them and that a dependent request sees the preceding write.

// File: rtl/rtu_pkg.sv
package rtu_pkg;

    typedef enum logic [2:0] {
        FN_COPY  = 3'd0,
        FN_HI2LO = 3'd1,
        FN_LO2HI = 3'd2,
        FN_DEC1  = 3'd3,
        FN_DEC2  = 3'd4,
        FN_INC1  = 3'd5,
        FN_INC2  = 3'd6,
        FN_NONE  = 3'd7
    } rtu_fn_e;

    function automatic logic [31:0] rtu_seed(input int idx);
        logic [31:0] prod;
        prod = 32'(idx) * 32'h0000_1357;
        return prod ^ 32'h0000_A5C3;
    endfunction

endpackage

// File: rtl/rtu_regfile.sv
module rtu_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 16,
    parameter int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_a,
    output logic [DW-1:0] rd_a,
    input  logic [AW-1:0] ra_b,
    output logic [DW-1:0] rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd
);
    import rtu_pkg::*;

    logic [DW-1:0] rf_q [NREG];
    logic [DW-1:0] rf_d [NREG];

    assign rd_a = rf_q[ra_a];
    assign rd_b = rf_q[ra_b];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            rf_d[i] = rf_q[i];
        end
        if (we) begin
            rf_d[wa] = wd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                rf_q[i] <= DW'(rtu_seed(i));
            end
        end else begin
            for (int i = 0; i < NREG; i++) begin
                rf_q[i] <= rf_d[i];
            end
        end
    end

    // R7: the addressed entry holds the written value after the edge
    assert_rf_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(we) |-> rf_q[$past(wa)] == $past(wd));

endmodule

// File: rtl/rtu_xfer_alu.sv
module rtu_xfer_alu #(
    parameter int DW = 16
) (
    input  rtu_pkg::rtu_fn_e fn,
    input  logic [DW-1:0]    dst_val,
    input  logic [DW-1:0]    src_val,
    output logic [DW-1:0]    res,
    output logic             wr
);
    import rtu_pkg::*;

    localparam int HB = DW / 2;

    always_comb begin
        res = '0;
        wr  = 1'b1;
        unique case (fn)
            FN_COPY:  res = src_val;
            FN_HI2LO: res = {dst_val[DW-1:HB], src_val[DW-1:HB]};
            FN_LO2HI: res = {src_val[HB-1:0], dst_val[HB-1:0]};
            FN_DEC1:  res = src_val - DW'(1);
            FN_DEC2:  res = src_val - DW'(2);
            FN_INC1:  res = src_val + DW'(1);
            FN_INC2:  res = src_val + DW'(2);
            default: begin
                res = '0;
                wr  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rtu_xfer_unit.sv
module rtu_xfer_unit #(
    parameter int DW   = 16,
    parameter int NREG = 16,
    parameter int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic [2:0]    func_i,
    input  logic [AW-1:0] rx_i,
    input  logic [AW-1:0] ry_i,
    output logic          wb_en_o,
    output logic [AW-1:0] wb_idx_o,
    output logic [DW-1:0] wb_data_o
);
    import rtu_pkg::*;

    localparam int HB = DW / 2;

    typedef struct packed {
        logic          wb_en;
        logic [AW-1:0] wb_idx;
        logic [DW-1:0] wb_data;
    } wb_state_t;

    wb_state_t     st_d, st_q;
    rtu_fn_e       fn;
    logic [DW-1:0] rd_a, rd_b, alu_res;
    logic          alu_wr;

    assign fn = rtu_fn_e'(func_i);

    rtu_regfile #(.DW(DW), .NREG(NREG), .AW(AW)) regs_i (
        .clk  (clk),
        .rst_n(rst_n),
        .ra_a (rx_i),
        .rd_a (rd_a),
        .ra_b (ry_i),
        .rd_b (rd_b),
        .we   (st_d.wb_en),
        .wa   (rx_i),
        .wd   (alu_res)
    );

    rtu_xfer_alu #(.DW(DW)) alu_i (
        .fn     (fn),
        .dst_val(rd_a),
        .src_val(rd_b),
        .res    (alu_res),
        .wr     (alu_wr)
    );

    always_comb begin
        st_d         = '0;
        st_d.wb_idx  = rx_i;
        st_d.wb_en   = valid_i && alu_wr;
        if (st_d.wb_en) begin
            st_d.wb_data = alu_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wb_en_o   = st_q.wb_en;
    assign wb_idx_o  = st_q.wb_idx;
    assign wb_data_o = st_q.wb_data;

    assert_idle_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(valid_i) |-> !wb_en_o);

    assert_copy_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(valid_i) && $past(func_i) == 3'd0) |-> wb_data_o == $past(rd_b));

    assert_hi2lo_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(valid_i) && $past(func_i) == 3'd1) |-> wb_data_o[DW-1:HB] == $past(rd_a[DW-1:HB]));

    assert_wb_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> wb_idx_o == $past(rx_i));

endmodule

// File: tb/rtu_xfer_unit_tb_top.sv
module rtu_xfer_unit_tb_top;

    typedef struct {
        logic        en;
        logic [3:0]  idx;
        logic [15:0] data;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [2:0]  func_i = '0;
    logic [3:0]  rx_i = '0;
    logic [3:0]  ry_i = '0;
    logic        wb_en_o;
    logic [3:0]  wb_idx_o;
    logic [15:0] wb_data_o;

    logic [15:0] mdl [16];
    exp_t        expq [$];
    int          checks = 0;
    int          fails  = 0;
    int          cycles = 0;
    bit          done   = 1'b0;

    always #4 clk = ~clk;

    rtu_xfer_unit dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .func_i(func_i),
        .rx_i(rx_i), .ry_i(ry_i), .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o),
        .wb_data_o(wb_data_o)
    );

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic op(input logic v, input logic [2:0] f, input logic [3:0] x,
                      input logic [3:0] y, input string tag);
        exp_t        e;
        logic [15:0] s, d, r;
        @(negedge clk);
        valid_i = v; func_i = f; rx_i = x; ry_i = y;
        s = mdl[y]; d = mdl[x];
        e.en = v && (f != 3'd7);
        case (f)
            3'd0: r = s;
            3'd1: r = {d[15:8], s[15:8]};
            3'd2: r = {s[7:0], d[7:0]};
            3'd3: r = s - 16'd1;
            3'd4: r = s - 16'd2;
            3'd5: r = s + 16'd1;
            3'd6: r = s + 16'd2;
            default: r = 16'h0;
        endcase
        e.idx  = x;
        e.data = e.en ? r : 16'h0;
        e.tag  = tag;
        if (e.en) mdl[x] = r;
        expq.push_back(e);
    endtask

    // monitor: compares each result one cycle after its request
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (expq.size() > 0) begin
                exp_t e;
                e = expq.pop_front();
                chk({e.tag, " en"}, 32'(wb_en_o), 32'(e.en));
                chk({e.tag, " data"}, 32'(wb_data_o), 32'(e.data));
                if (e.en) chk({e.tag, " idx"}, 32'(wb_idx_o), 32'(e.idx));
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = 16'((i * 32'h1357) ^ 32'hA5C3);
        repeat (3) @(posedge clk);
        #2;
        chk("R1 reset en", 32'(wb_en_o), 0);
        chk("R1 reset data", 32'(wb_data_o), 0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #2;
        chk("R1 post-reset en", 32'(wb_en_o), 0);

        op(1, 3'd0, 4'd1, 4'd3, "R1 R2 copy seed");
        op(1, 3'd1, 4'd2, 4'd4, "R3 hi2lo");
        op(1, 3'd2, 4'd5, 4'd6, "R4 lo2hi");
        op(1, 3'd3, 4'd7, 4'd0, "R5 dec1");
        op(1, 3'd4, 4'd8, 4'd9, "R5 dec2");
        op(1, 3'd5, 4'd10, 4'd11, "R6 inc1");
        op(1, 3'd6, 4'd12, 4'd13, "R6 inc2");
        op(1, 3'd0, 4'd15, 4'd11, "R7 src untouched");
        op(1, 3'd0, 4'd0, 4'd10, "R9 back-to-back read");
        op(1, 3'd1, 4'd3, 4'd3, "R3 R7 same reg hi2lo");
        op(1, 3'd2, 4'd4, 4'd4, "R4 R7 same reg lo2hi");
        op(1, 3'd7, 4'd6, 4'd1, "R8 code7");
        op(1, 3'd0, 4'd9, 4'd6, "R8 code7 left reg");
        op(0, 3'd0, 4'd6, 4'd2, "R8 idle");
        op(1, 3'd0, 4'd14, 4'd6, "R8 idle left reg");
        while (mdl[14] != 16'hFFFF) op(1, 3'd5, 4'd14, 4'd14, "R6 R7 self inc");
        op(1, 3'd6, 4'd14, 4'd14, "R6 wrap up");
        op(1, 3'd4, 4'd14, 4'd14, "R5 wrap down");
        op(1, 3'd0, 4'd13, 4'd14, "R9 chained copy");
        op(0, 3'd0, 4'd0, 4'd0, "R8 trailing idle");
        @(negedge clk) valid_i = 1'b0;
        while (expq.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        report();
    end

endmodule